// File: doc/BRIEF.md
# Two-Input Ones-Count Modulo-Four Flag

This block watches two single-bit data lines on every rising clock edge. It keeps a running total of how many of those lines were high, summed over all cycles since reset. It stores only the total modulo four, as a small residue register. The single output flag is high whenever that total is an exact multiple of four.

A build-time parameter picks how the flag is timed. In the registered (Moore) form, the flag comes only from the stored residue, so it shows the total up to the previous clock edge. In the combinational (Mealy) form, the flag already includes the bits being presented in the current cycle. That form answers one cycle earlier, but it has a path from input to output.

Reset is synchronous and active low, and it returns the running total to zero. The block is meant to sit beside a pair of event strobes, where a downstream stage needs to know when the event count lines up on a group of four.

Top module: `ones_mod4_flag`

## Requirements
- R1: When `rst_n` is low at a rising edge, the residue becomes 0. In the registered form, `flag_z` is 1 in the cycle after that edge.
- R2: At a rising edge with `rst_n` high and both `bit_a` and `bit_b` low, the residue keeps its value.
- R3: At a rising edge with `rst_n` high and exactly one of `bit_a`, `bit_b` high, the residue advances by 1.
- R4: At a rising edge with `rst_n` high and both inputs high, the residue advances by 2.
- R5: The residue wraps modulo 4, so it always equals the total number of sampled 1s since the last reset, modulo 4 (3 plus 1 gives 0, 3 plus 2 gives 1).
- R6: With `OUT_FORM` set to the registered form (encoding 0), `flag_z` is 1 exactly when the stored residue is 0. It does not depend on the current inputs.
- R7: With `OUT_FORM` set to the combinational form (encoding 1), `flag_z` is 1 exactly when the stored residue plus `bit_a` plus `bit_b`, modulo 4, is 0, all evaluated within the current cycle.
- R8: Input bits present at an edge where `rst_n` is low are not counted. Reset takes priority over any increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_a | input | 1 | First counted data bit |
| bit_b | input | 1 | Second counted data bit |
| flag_z | output | 1 | High when the ones total is a multiple of four |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is reset and increment: reset is asserted while both inputs are high. The bench judges this by whether the flag afterwards matches a total of zero. The second pair is the double step and the wrap: both inputs are raised with the residue at 2 and at 3, so the residue wraps to 0 and to 1. A behavioural integer model follows the total every clock, and both output forms, instantiated side by side, are compared against it.

// File: rtl/ones_mod4_pkg.sv
// Shared types for the ones-count modulo flag.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ones_mod4_pkg;

    // Output timing variant of the flag.
    typedef enum logic {
        FORM_MOORE = 1'b0,
        FORM_MEALY = 1'b1
    } out_form_e;

    // Default residue width: modulus 2**2 = 4.
    localparam int unsigned DEF_RES_W = 2;

endpackage

// File: rtl/ones_mod4_popcnt.sv
// Counts the high bits of a small input vector.
// Assumes: CNT_W is wide enough to hold N_IN.
module ones_mod4_popcnt #(
    parameter int unsigned N_IN  = 2,
    parameter int unsigned CNT_W = $clog2(N_IN + 1)
) (
    input  logic [N_IN-1:0]  bits_i,
    output logic [CNT_W-1:0] ones_o
);

    // Sum every input bit into the count.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < N_IN; i++) begin
            ones_o = ones_o + CNT_W'(bits_i[i]);
        end
    end

endmodule

// File: rtl/ones_mod4_residue.sv
// Holds the running total modulo 2**RES_W and presents the next value.
// Assumes: synchronous active-low reset; truncation gives the modulus.
module ones_mod4_residue #(
    parameter int unsigned RES_W = 2,
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] step_i,
    output logic [RES_W-1:0] res_o,
    output logic [RES_W-1:0] next_o
);

    logic [RES_W-1:0] res_q;

    // Add this cycle's step; the carry beyond RES_W is dropped.
    always_comb begin
        next_o = res_q + RES_W'(step_i);
    end

    // Register the residue; reset takes priority over the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= next_o;
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/ones_mod4_zero_flag.sv
// Raises the flag when the selected residue is zero.
// Assumes: OUT_FORM is fixed at build time.
module ones_mod4_zero_flag
    import ones_mod4_pkg::*;
#(
    parameter int unsigned RES_W    = 2,
    parameter out_form_e   OUT_FORM = FORM_MOORE
) (
    input  logic [RES_W-1:0] res_i,
    input  logic [RES_W-1:0] next_i,
    output logic             flag_o
);

    logic [RES_W-1:0] pick;

    // Choose the stored residue or the one including current inputs.
    always_comb begin
        pick   = (OUT_FORM == FORM_MEALY) ? next_i : res_i;
        flag_o = (pick == '0);
    end

endmodule

// File: rtl/ones_mod4_flag.sv
// Top: flags when the ones seen on two inputs total a multiple of 2**RES_W.
// Assumes: inputs stable around the rising edge; synchronous active-low reset.
module ones_mod4_flag
    import ones_mod4_pkg::*;
#(
    parameter int unsigned RES_W    = DEF_RES_W,
    parameter out_form_e   OUT_FORM = FORM_MOORE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_a,
    input  logic bit_b,
    output logic flag_z
);

    localparam int unsigned N_IN  = 2;
    localparam int unsigned CNT_W = $clog2(N_IN + 1);

    logic [N_IN-1:0]  in_vec;
    logic [CNT_W-1:0] ones;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] res_next;

    assign in_vec = {bit_b, bit_a};

    ones_mod4_popcnt #(
        .N_IN  (N_IN),
        .CNT_W (CNT_W)
    ) popcnt_i (
        .bits_i (in_vec),
        .ones_o (ones)
    );

    ones_mod4_residue #(
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) residue_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (ones),
        .res_o  (res_q),
        .next_o (res_next)
    );

    ones_mod4_zero_flag #(
        .RES_W    (RES_W),
        .OUT_FORM (OUT_FORM)
    ) flag_i (
        .res_i  (res_q),
        .next_i (res_next),
        .flag_o (flag_z)
    );

endmodule

// File: rtl/ones_mod4_flag_chk.sv
// Property checker bound to the top; watches the ports and the residue.
// Assumes: rst_n is low at the first clock edge.
module ones_mod4_flag_chk
    import ones_mod4_pkg::*;
#(
    parameter int unsigned RES_W    = 2,
    parameter out_form_e   OUT_FORM = FORM_MOORE
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_a,
    input logic             bit_b,
    input logic             flag_z,
    input logic [RES_W-1:0] residue
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (residue == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_a) && !$past(bit_b)) |-> $stable(residue));

    // R4
    pair_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bit_a) && $past(bit_b)) |-> (residue[0] == $past(residue[0])));

    // R5
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (residue == RES_W'($past(residue) + RES_W'($past(bit_a)) + RES_W'($past(bit_b)))));

    generate
        if (OUT_FORM == FORM_MEALY) begin : g_mealy
            // R7
            mealy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                flag_z == (RES_W'(residue + RES_W'(bit_a) + RES_W'(bit_b)) == '0));
        end else begin : g_moore
            // R6
            moore_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                flag_z == (residue == '0));
        end
    endgenerate

endmodule

bind ones_mod4_flag ones_mod4_flag_chk #(
    .RES_W    (RES_W),
    .OUT_FORM (OUT_FORM)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_a   (bit_a),
    .bit_b   (bit_b),
    .flag_z  (flag_z),
    .residue (res_q)
);

// File: tb/ones_mod4_flag_tb.sv
`timescale 1ns/1ps
module ones_mod4_flag_tb_top;
    import ones_mod4_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_a = 1'b0;
    logic bit_b = 1'b0;
    logic flag_moore;
    logic flag_mealy;

    int checks = 0;
    int fails = 0;
    int total = 0;
    bit model_valid = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    ones_mod4_flag #(.RES_W(2), .OUT_FORM(FORM_MOORE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_a(bit_a), .bit_b(bit_b), .flag_z(flag_moore)
    );

    ones_mod4_flag #(.RES_W(2), .OUT_FORM(FORM_MEALY)) dut_mealy_i (
        .clk(clk), .rst_n(rst_n), .bit_a(bit_a), .bit_b(bit_b), .flag_z(flag_mealy)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b (total %0d)", tag, got, exp, total);
        end
    endtask

    // One cycle: drive at falling edge, compare both forms, update model at rising edge.
    task automatic step(input logic rn, input logic a, input logic b, input string tag);
        @(negedge clk);
        rst_n = rn;
        bit_a = a;
        bit_b = b;
        #1;
        if (model_valid) begin
            check({tag, " R6 moore"}, flag_moore, (total % 4) == 0);
            check({tag, " R7 mealy"}, flag_mealy, ((total + a + b) % 4) == 0);
        end
        @(posedge clk);
        if (!rn) begin
            total = 0;
            model_valid = 1'b1;
        end else begin
            total = total + a + b;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R8: inputs high during reset are not counted
        step(1'b0, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b1, "R8");
        // R1: residue 0 after reset, registered flag high
        step(1'b1, 1'b0, 1'b0, "R1");
        // R2: idle cycles hold the total
        step(1'b1, 1'b0, 1'b0, "R2");
        // R3: single bit on each line
        step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b0, "R3");
        // R5: residue 3 plus 1 wraps to 0
        step(1'b1, 1'b0, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        // R4: both high, 0 -> 2 -> 0
        step(1'b1, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, "R3");
        // R5: residue 3 plus 2 wraps to 1
        step(1'b1, 1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        // R8: reset in the same cycle as a double step
        step(1'b0, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b0, "R1");
        // Pseudo-random stream, with occasional resets
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((lfsr[7:3] != 5'd0), lfsr[0], lfsr[1], "R5 rand");
        end
        step(1'b1, 1'b0, 1'b0, "R2");
        finish_run();
    end

endmodule